// File: doc/BRIEF.md
# Load Store-Wait Dependence Predictor

This block predicts, for each load, whether it is likely to read data that an older store has not yet written. It keeps a table of one-bit wait flags addressed by the load's instruction address. Whenever a load is found to have run ahead of a store it depended on, the pipeline reports that load's address and the matching flag is raised. When a load is fetched, its flag is read out and handed on with the instruction to the issue stage.

At issue time the block turns that carried flag into a hold decision. A flagged load stays in the queue for as long as any older store is still outstanding. An unflagged load is released without waiting. Flags are only ever set; they never count down. Instead, the whole table is wiped at a programmable cycle interval, so loads whose dependence has gone away get back their freedom to run early.

Top module: `ldDepPredictor`

## Requirements
- R1: After reset, `predValid` is 0 and every table flag is 0, so any lookup returns `predWait` = 0.
- R2: The table index is instruction address bits [11:2]. Addresses that differ only in bits [1:0] or above bit 11 share a flag. Addresses that differ anywhere in bits [11:2] use separate flags.
- R3: A cycle with `violValid` high sets the flag selected by `violPc`. The flag then reads 1 on every later lookup until the next wipe.
- R4: A lookup with `fetchValid` high in one cycle drives `predValid` high in the next cycle, with `predWait` equal to the flag. `predValid` is low in the cycle after any cycle with `fetchValid` low.
- R5: A lookup in the same cycle as a set to the same index returns 1. A set to a different index in that cycle does not change the lookup result.
- R6: `issueHold` is 1 exactly when `issueLdWait` and `olderStorePending` are both 1. It is combinational.
- R7: When `clrInterval` = N > 0, every flag is wiped once every N cycles. The first wipe happens on the N-th clock edge after reset is released, and each later wipe comes N edges after the previous one. When N = 0, no wipe ever happens and set flags persist.
- R8: A wipe takes priority over a set in the same cycle. A lookup in a wipe cycle returns 0.
- R9: `predWait` is 0 whenever `predValid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clrInterval | input | CNT_W | Wipe period in cycles; 0 disables wiping |
| violValid | input | 1 | An ordering violation was detected for a load |
| violPc | input | PC_W | Instruction address of the violating load |
| fetchValid | input | 1 | A load is being fetched and needs its flag |
| fetchPc | input | PC_W | Instruction address of the fetched load |
| predValid | output | 1 | Lookup result is valid (one cycle after `fetchValid`) |
| predWait | output | 1 | Predicted store-wait flag for the looked-up load |
| issueLdWait | input | 1 | Wait flag carried by the load at issue |
| olderStorePending | input | 1 | At least one older store has not completed |
| issueHold | output | 1 | Hold the load in the issue queue |

## Verification
The lookup result is registered once: the bench drives `fetchValid` before an edge and reads `predValid` and `predWait` at the next falling edge. Sets and wipes land at that same edge, and the same-cycle forwarding makes a set or a wipe visible to a lookup made in that cycle. The wipe counter starts at the release of reset, so each wipe test resets the block first. It then counts clock edges by hand, so that lookups fall on the edge just before a wipe and on the wipe edge itself. The hold output has no register and is checked one time step after its inputs change.

// File: rtl/ldpPkg.sv
package ldpPkg;

  // Strobes from the control side to the flag table.
  typedef struct packed {
    logic wipe;   // clear every flag this cycle
    logic setEn;  // raise the flag at the violation index
    logic rdEn;   // perform a lookup at the fetch index
  } tblStrobe_t;

endpackage

// File: rtl/ldpCtrl.sv
module ldpCtrl
  import ldpPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] clrInterval,
  input  logic             violValid,
  input  logic             fetchValid,
  input  logic             issueLdWait,
  input  logic             olderStorePending,
  output tblStrobe_t       strobe,
  output logic             issueHold
);

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cycCnt;
  logic [EXT_W-1:0] cntNext;
  logic             wipeDue;

  // Cycles elapsed since reset or since the last wipe.
  assign cntNext = {1'b0, cycCnt} + EXT_W'(1);
  assign wipeDue = (clrInterval != '0) && (cntNext >= {1'b0, clrInterval});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cycCnt <= '0;
    else if (wipeDue) cycCnt <= '0;
    else              cycCnt <= cycCnt + CNT_W'(1);
  end

  // A wipe overrides any set in the same cycle.
  always_comb begin
    strobe.wipe  = wipeDue;
    strobe.setEn = violValid && !wipeDue;
    strobe.rdEn  = fetchValid;
  end

  // Flagged loads wait for all older stores to drain.
  assign issueHold = issueLdWait && olderStorePending;

endmodule

// File: rtl/ldpTable.sv
module ldpTable
  import ldpPkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFS_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  tblStrobe_t      strobe,
  input  logic [PC_W-1:0] violPc,
  input  logic [PC_W-1:0] fetchPc,
  output logic            predValid,
  output logic            predWait
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] waitBits;
  logic [IDX_W-1:0]   setIdx;
  logic [IDX_W-1:0]   rdIdx;
  logic               rdBit;
  logic               unusedPcBits;

  assign setIdx       = violPc[OFS_W +: IDX_W];
  assign rdIdx        = fetchPc[OFS_W +: IDX_W];
  assign unusedPcBits = ^{violPc, fetchPc};

  // One flop per flag: set-only, wiped in bulk.
  for (genvar e = 0; e < ENTRIES; e++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        waitBits[e] <= 1'b0;
      else if (strobe.wipe)
        waitBits[e] <= 1'b0;
      else if (strobe.setEn && (setIdx == IDX_W'(e)))
        waitBits[e] <= 1'b1;
    end
  end

  // A lookup sees the value the flag holds after this cycle's update.
  always_comb begin
    if (strobe.wipe)
      rdBit = 1'b0;
    else if (strobe.setEn && (setIdx == rdIdx))
      rdBit = 1'b1;
    else
      rdBit = waitBits[rdIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      predValid <= 1'b0;
      predWait  <= 1'b0;
    end else begin
      predValid <= strobe.rdEn;
      predWait  <= strobe.rdEn && rdBit;
    end
  end

endmodule

// File: rtl/ldDepPredictor.sv
module ldDepPredictor
  import ldpPkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFS_W = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] clrInterval,
  input  logic             violValid,
  input  logic [PC_W-1:0]  violPc,
  input  logic             fetchValid,
  input  logic [PC_W-1:0]  fetchPc,
  output logic             predValid,
  output logic             predWait,
  input  logic             issueLdWait,
  input  logic             olderStorePending,
  output logic             issueHold
);

  tblStrobe_t strobe;

  ldpCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk               (clk),
    .rstN              (rstN),
    .clrInterval       (clrInterval),
    .violValid         (violValid),
    .fetchValid        (fetchValid),
    .issueLdWait       (issueLdWait),
    .olderStorePending (olderStorePending),
    .strobe            (strobe),
    .issueHold         (issueHold)
  );

  ldpTable #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) uTable (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .violPc    (violPc),
    .fetchPc   (fetchPc),
    .predValid (predValid),
    .predWait  (predWait)
  );

endmodule

// File: rtl/ldpChecker.sv
module ldpChecker #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFS_W = 2,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] clrInterval,
  input logic             violValid,
  input logic [PC_W-1:0]  violPc,
  input logic             fetchValid,
  input logic [PC_W-1:0]  fetchPc,
  input logic             predValid,
  input logic             predWait,
  input logic             issueLdWait,
  input logic             olderStorePending,
  input logic             issueHold
);

  logic sameIdx;
  logic unusedChkBits;

  assign sameIdx       = violPc[OFS_W +: IDX_W] == fetchPc[OFS_W +: IDX_W];
  assign unusedChkBits = ^{violPc, fetchPc};

  // R4: a lookup yields a valid result one cycle later
  a_r4_valid_follows_fetch: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |=> predValid);

  // R4: no lookup, no valid result next cycle
  a_r4_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |=> !predValid);

  // R9: the prediction is qualified by its valid
  a_r9_wait_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    !predValid |-> !predWait);

  // R5: same-cycle set and lookup on one index returns the new value
  a_r5_set_forward: assert property (@(posedge clk) disable iff (!rstN)
    (clrInterval == '0 && violValid && fetchValid && sameIdx) |=> predWait);

  // R8: with a wipe every cycle, a set cannot be seen by a lookup
  a_r8_wipe_beats_set: assert property (@(posedge clk) disable iff (!rstN)
    (clrInterval == CNT_W'(1) && fetchValid) |=> !predWait);

  // R6: no outstanding store, no hold
  a_r6_no_store_no_hold: assert property (@(posedge clk) disable iff (!rstN)
    !olderStorePending |-> !issueHold);

  // R6: unflagged load is never held
  a_r6_no_flag_no_hold: assert property (@(posedge clk) disable iff (!rstN)
    !issueLdWait |-> !issueHold);

endmodule

bind ldDepPredictor ldpChecker #(
  .PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .CNT_W(CNT_W)
) uChk (
  .clk               (clk),
  .rstN              (rstN),
  .clrInterval       (clrInterval),
  .violValid         (violValid),
  .violPc            (violPc),
  .fetchValid        (fetchValid),
  .fetchPc           (fetchPc),
  .predValid         (predValid),
  .predWait          (predWait),
  .issueLdWait       (issueLdWait),
  .olderStorePending (olderStorePending),
  .issueHold         (issueHold)
);

// File: tb/sim_ldDepPredictor.sv
`timescale 1ns/1ps
module sim_ldDepPredictor;

  localparam int PC_W  = 32;
  localparam int IDX_W = 10;
  localparam int OFS_W = 2;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN;
  logic [CNT_W-1:0] clrInterval;
  logic             violValid;
  logic [PC_W-1:0]  violPc;
  logic             fetchValid;
  logic [PC_W-1:0]  fetchPc;
  logic             predValid;
  logic             predWait;
  logic             issueLdWait;
  logic             olderStorePending;
  logic             issueHold;

  int testCnt = 0;
  int failCnt = 0;

  always #2 clk = ~clk;

  ldDepPredictor #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .clrInterval(clrInterval),
    .violValid(violValid), .violPc(violPc),
    .fetchValid(fetchValid), .fetchPc(fetchPc),
    .predValid(predValid), .predWait(predWait),
    .issueLdWait(issueLdWait), .olderStorePending(olderStorePending),
    .issueHold(issueHold)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // One clock edge; returns at the following falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(input logic [CNT_W-1:0] interval);
    rstN = 1'b0;
    clrInterval = interval;
    violValid = 1'b0; violPc = '0;
    fetchValid = 1'b0; fetchPc = '0;
    issueLdWait = 1'b0; olderStorePending = 1'b0;
    step();
    step();
    rstN = 1'b1;
  endtask

  task automatic setViol(input logic [PC_W-1:0] pc);
    violValid = 1'b1; violPc = pc;
    step();
    violValid = 1'b0;
  endtask

  task automatic lookup(input logic [PC_W-1:0] pc, input logic exp, input string req);
    fetchValid = 1'b1; fetchPc = pc;
    step();
    fetchValid = 1'b0;
    chk({req, " predValid"}, predValid, 1'b1);
    chk({req, " predWait"}, predWait, exp);
  endtask

  task automatic testReset();
    doReset('0);
    chk("R1 predValid after reset", predValid, 1'b0);
    lookup(32'h0000_0000, 1'b0, "R1 idx 0");
    lookup(32'h0000_0ffc, 1'b0, "R1 idx max");
    lookup(32'h0000_0480, 1'b0, "R1 idx mid");
  endtask

  task automatic testSetLookup();
    doReset('0);
    lookup(32'h0000_1000, 1'b0, "R3 before set");
    setViol(32'h0000_1000);
    lookup(32'h0000_1000, 1'b1, "R3 after set");
    step();
    chk("R4 valid drops when idle", predValid, 1'b0);
    chk("R9 wait low when not valid", predWait, 1'b0);
    repeat (20) step();
    lookup(32'h0000_1000, 1'b1, "R3 persists");
  endtask

  task automatic testAlias();
    doReset('0);
    setViol(32'h0000_0124);
    lookup(32'h0000_0127, 1'b1, "R2 byte offset ignored");
    lookup(32'h0000_1124, 1'b1, "R2 bit 12 ignored");
    lookup(32'h8000_0124, 1'b1, "R2 bit 31 ignored");
    lookup(32'h0000_0128, 1'b0, "R2 bit 2 distinct");
    lookup(32'h0000_0924, 1'b0, "R2 bit 11 distinct");
  endtask

  task automatic testForward();
    doReset('0);
    violValid = 1'b1; violPc = 32'h0000_2008;
    lookup(32'h0000_2008, 1'b1, "R5 same-cycle same index");
    violValid = 1'b1; violPc = 32'h0000_2010;
    lookup(32'h0000_200c, 1'b0, "R5 same-cycle other index");
    violValid = 1'b0;
    lookup(32'h0000_2010, 1'b1, "R3 other index was set");
  endtask

  task automatic testHold();
    for (int k = 0; k < 4; k++) begin
      issueLdWait = k[0];
      olderStorePending = k[1];
      #1;
      chk($sformatf("R6 hold flag=%0d store=%0d", k[0], k[1]), issueHold, k[0] & k[1]);
    end
    issueLdWait = 1'b0;
    olderStorePending = 1'b0;
  endtask

  task automatic testWipe();
    doReset(CNT_W'(8));
    setViol(32'h0000_0040);                           // edge 1
    repeat (5) step();                                // edges 2..6
    lookup(32'h0000_0040, 1'b1, "R7 before first wipe"); // edge 7
    violValid = 1'b1; violPc = 32'h0000_0040;
    lookup(32'h0000_0040, 1'b0, "R8 wipe beats set and lookup"); // edge 8
    violValid = 1'b0;
    lookup(32'h0000_0040, 1'b0, "R8 set lost to wipe");  // edge 9
    setViol(32'h0000_0040);                           // edge 10
    repeat (4) step();                                // edges 11..14
    lookup(32'h0000_0040, 1'b1, "R7 before second wipe"); // edge 15
    lookup(32'h0000_0040, 1'b0, "R7 second wipe at period"); // edge 16
  endtask

  task automatic testNoWipe();
    doReset('0);
    setViol(32'h0000_0300);
    repeat (200) step();
    lookup(32'h0000_0300, 1'b1, "R7 interval zero never wipes");
  endtask

  task automatic testWipeEveryCycle();
    doReset(CNT_W'(1));
    setViol(32'h0000_0500);
    lookup(32'h0000_0500, 1'b0, "R8 set never survives");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    testReset();
    testSetLookup();
    testAlias();
    testForward();
    testHold();
    testWipe();
    testNoWipe();
    testWipeEveryCycle();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule